// File: doc/BRIEF.md
# Mailbox I2C Master

This block is an I2C master that a host drives through four 16-bit registers. The host puts outgoing bytes in a write data mailbox. It then writes a command word that names the 7-bit target, the direction and the data length, which is none, one or two bytes. That write starts the transaction. The engine produces START, the address byte, the data bytes and STOP on open-drain SCL and SDA. It reports completion through sticky status bits, and received bytes appear in a read data mailbox.

A hold option ends a command without STOP and keeps SCL low. The next command then opens with a repeated START, which lets a host chain an address write and a data read into one bus transaction. The SCL rate comes from the system clock through a divider set on the `clk_div` input. Clock stretching, arbitration and target mode are not provided.

Register map (`reg_addr`):
- 0: command word.
- 1: write data mailbox.
- 2: read data mailbox, read only.
- 3: status. Writing 1 to a bit clears it.

Top module: `mbx_i2c_master`

## Requirements
- R1: After reset, busy is 0, the status register reads 0, and both `scl_oe` and `sda_oe` are 0 (bus released).
- R2: In the command word, bits 6:0 are the target address and bit 10 set means write (clear means read). Bit 11 set selects two data bytes. Bit 12 set selects no data byte and overrides bit 11. Bit 13 is hold, and bits 15:14 must equal 2. The first byte on the bus is {address, ~bit10}.
- R3: A write sends write-mailbox bits 7:0 first and bits 15:8 second, each byte MSB first.
- R4: A read places the first received byte in read-mailbox bits 7:0 and the second in bits 15:8. The master ACKs every byte except the last, which it NACKs. A one-byte read leaves bits 15:8 at 0.
- R5: Completion of a write sets status bit 14, and completion of a read sets bit 15. On error, bit 13 is set instead of either. Busy goes low in the same cycle the status bit appears.
- R6: A NACK on the address or on a written byte ends the data phase without sending further bytes, issues STOP (unless hold is set) and sets status bit 13.
- R7: A command with no data bytes performs START, address, STOP. With an acknowledge it sets the direction bit. Without one it sets bit 13. The read mailbox is left unchanged.
- R8: With hold set, no STOP is issued and SCL stays driven low after completion. The next command starts with a repeated START and no STOP in between.
- R9: Writing status (address 3) with a 1 in bits 15:13 clears those bits. A 0 bit leaves its bit unchanged.
- R10: A command written while busy is ignored and does not alter the running transaction.
- R11: A command whose bits 15:14 are not 2 causes no bus activity. It leaves busy low and sets status bit 13 on the next cycle.
- R12: Within a transaction, successive SCL rising edges are exactly 4*(clk_div+1) clock cycles apart.
- R13: Each command produces exactly one START (or repeated START) and at most one STOP. SDA changes only while SCL is low, apart from those two conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 16 | Quarter-bit length minus one, in clock cycles |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after reg_addr |
| busy | output | 1 | A command is in progress |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| sda_oe | output | 1 | 1 drives SDA low, 0 releases it |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
A target model on the bus logs every byte, START, STOP and master acknowledge. It also measures the spacing of SCL edges.

A corrupt bit counter or a wrong byte index shows up within one byte time, in one of three ways:
- the logged bytes differ from the write mailbox;
- the read mailbox holds misordered bytes;
- the master ACK/NACK pattern is wrong.

A wrong phase or hold state shows as extra or missing START/STOP conditions, or as an uneven SCL period, within the same command. A wrong completion path shows as the wrong sticky status bit when the command finishes.

// File: rtl/mbx_i2c_pkg.sv
package mbx_i2c_pkg;
  // command word fields
  localparam int CMD_WR_BIT     = 10;
  localparam int CMD_TWO_BIT    = 11;
  localparam int CMD_NODATA_BIT = 12;
  localparam int CMD_HOLD_BIT   = 13;
  localparam int CMD_MODE_LSB   = 14;
  localparam logic [1:0] MODE_NATIVE = 2'd2;
  // status bits
  localparam int ST_ERR_BIT = 13;
  localparam int ST_TX_BIT  = 14;
  localparam int ST_RX_BIT  = 15;
  // register addresses
  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_WEXT = 2'd1;
  localparam logic [1:0] RA_REXT = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  typedef enum logic [1:0] {EN_IDLE, EN_START, EN_BYTE, EN_STOP} eng_st_t;
endpackage

// File: rtl/mbx_i2c_tick.sv
module mbx_i2c_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick); // R12
endmodule

// File: rtl/mbx_i2c_engine.sv
module mbx_i2c_engine
  import mbx_i2c_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                go,
  input  logic [ADDR_W-1:0]   go_addr,
  input  logic                go_rnw,
  input  logic [1:0]          go_nbytes,
  input  logic                go_hold,
  input  logic [2*BYTE_W-1:0] go_tx,
  input  logic                sda_in,
  output logic                active,
  output logic                done,
  output logic                err,
  output logic [2*BYTE_W-1:0] rx,
  output logic                scl_oe,
  output logic                sda_oe
);
  localparam int BC_W = $clog2(BYTE_W + 1);
  localparam logic [BC_W-1:0] ACK_SLOT = BC_W'(BYTE_W);

  eng_st_t             st;
  logic [1:0]          q;
  logic [BC_W-1:0]     bitn;
  logic [1:0]          bidx;
  logic [BYTE_W-1:0]   shreg;
  logic                ackv, rnw, hold, held;
  logic [1:0]          nbytes;
  logic [2*BYTE_W-1:0] tx;
  logic                c_scl, c_sda, wrbyte;

  assign active = (st != EN_IDLE);
  assign wrbyte = (bidx == 2'd0) || !rnw;

  // line drive per phase: 1 = pull low
  always_comb begin
    c_scl = 1'b0;
    c_sda = 1'b0;
    unique case (st)
      EN_IDLE:  c_scl = held;
      EN_START: begin
        c_scl = (q == 2'd0) || (q == 2'd3);
        c_sda = (q >= 2'd2);
      end
      EN_BYTE: begin
        c_scl = (q == 2'd0) || (q == 2'd3);
        if (bitn != ACK_SLOT) c_sda = wrbyte && !shreg[BYTE_W-1];
        else                  c_sda = !wrbyte && (bidx != nbytes);
      end
      EN_STOP: begin
        c_scl = (q == 2'd0);
        c_sda = (q <= 2'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= EN_IDLE; q <= '0; bitn <= '0; bidx <= '0; shreg <= '0;
      ackv <= 1'b0; rnw <= 1'b0; hold <= 1'b0; held <= 1'b0; nbytes <= '0;
      tx <= '0; rx <= '0; err <= 1'b0; done <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done   <= 1'b0;
      scl_oe <= c_scl;
      sda_oe <= c_sda;
      if (st == EN_IDLE) begin
        if (go) begin
          st <= EN_START; q <= '0; rnw <= go_rnw; nbytes <= go_nbytes;
          hold <= go_hold; tx <= go_tx; shreg <= {go_addr, go_rnw};
          err <= 1'b0; rx <= '0;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        unique case (st)
          EN_START: if (q == 2'd3) begin
            st <= EN_BYTE; bitn <= '0; bidx <= '0; held <= 1'b0;
          end
          EN_BYTE: begin
            if (q == 2'd2) begin
              if (bitn == ACK_SLOT) ackv <= sda_in;
              else if (!wrbyte)     shreg <= {shreg[BYTE_W-2:0], sda_in};
            end
            if (q == 2'd3) begin
              if (bitn != ACK_SLOT) begin
                bitn <= bitn + 1'b1;
                if (wrbyte) shreg <= {shreg[BYTE_W-2:0], 1'b0};
              end else begin
                if (!wrbyte) begin
                  if (bidx == 2'd1) rx[BYTE_W-1:0]        <= shreg;
                  else              rx[2*BYTE_W-1:BYTE_W] <= shreg;
                end
                if ((wrbyte && ackv) || (bidx == nbytes)) begin
                  err <= wrbyte && ackv;
                  if (hold) begin
                    st <= EN_IDLE; held <= 1'b1; done <= 1'b1;
                  end else begin
                    st <= EN_STOP;
                  end
                end else begin
                  bidx  <= bidx + 2'd1;
                  bitn  <= '0;
                  shreg <= (bidx == 2'd0) ? tx[BYTE_W-1:0] : tx[2*BYTE_W-1:BYTE_W];
                end
              end
            end
          end
          EN_STOP: if (q == 2'd3) begin
            st <= EN_IDLE; held <= 1'b0; done <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == EN_BYTE && $past(st, 2) == EN_BYTE && !scl_oe && !$past(scl_oe))
    |-> $stable(sda_oe)); // R13
  AST_DONE_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == EN_IDLE)); // R5
  AST_HELD_KEEPS_SCL: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == EN_IDLE && $past(held)) |-> scl_oe); // R8
  AST_NO_BYTE_PAST_LEN: assert property (@(posedge clk) disable iff (rst)
    (st == EN_BYTE) |-> (bidx <= nbytes)); // R6
endmodule

// File: rtl/mbx_i2c_master.sv
module mbx_i2c_master
  import mbx_i2c_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [2*BYTE_W-1:0] reg_wdata,
  output logic [2*BYTE_W-1:0] reg_rdata,
  output logic                busy,
  output logic                scl_oe,
  output logic                sda_oe,
  input  logic                sda_in
);
  localparam int REG_W = 2 * BYTE_W;
  localparam int ST_W  = ST_RX_BIT - ST_ERR_BIT + 1;

  logic              sda_m, sda_s;
  logic              cmd_hit, mode_ok, go;
  logic [ADDR_W-1:0] c_addr;
  logic              c_rnw, c_hold;
  logic [1:0]        c_nb;
  logic [REG_W-1:0]  wext, rext, eng_rx;
  logic [ST_W-1:0]   status, st_set, st_clr; // [0]=err [1]=tx [2]=rx
  logic              eng_active, eng_done, eng_err, tick;

  assign cmd_hit = reg_we && (reg_addr == RA_CMD);
  assign mode_ok = (reg_wdata[CMD_MODE_LSB +: 2] == MODE_NATIVE);
  assign st_clr  = (reg_we && reg_addr == RA_STAT) ? reg_wdata[ST_RX_BIT:ST_ERR_BIT] : '0;

  always_comb begin
    st_set = '0;
    if (cmd_hit && !busy && !mode_ok) st_set[0] = 1'b1;
    if (eng_done) begin
      if (eng_err)    st_set[0] = 1'b1;
      else if (c_rnw) st_set[2] = 1'b1;
      else            st_set[1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_m <= 1'b1; sda_s <= 1'b1;
      busy <= 1'b0; go <= 1'b0; c_addr <= '0; c_rnw <= 1'b0; c_hold <= 1'b0;
      c_nb <= '0; wext <= '0; rext <= '0; status <= '0; reg_rdata <= '0;
    end else begin
      sda_m <= sda_in;
      sda_s <= sda_m;
      go    <= 1'b0;
      if (cmd_hit && !busy && mode_ok) begin
        go     <= 1'b1;
        busy   <= 1'b1;
        c_addr <= reg_wdata[ADDR_W-1:0];
        c_rnw  <= !reg_wdata[CMD_WR_BIT];
        c_hold <= reg_wdata[CMD_HOLD_BIT];
        c_nb   <= reg_wdata[CMD_NODATA_BIT] ? 2'd0 : (reg_wdata[CMD_TWO_BIT] ? 2'd2 : 2'd1);
      end else if (eng_done) begin
        busy <= 1'b0;
      end
      if (reg_we && reg_addr == RA_WEXT) wext <= reg_wdata;
      if (eng_done && c_rnw && !eng_err && c_nb != 2'd0) rext <= eng_rx;
      status <= (status & ~st_clr) | st_set;
      unique case (reg_addr)
        RA_WEXT: reg_rdata <= wext;
        RA_REXT: reg_rdata <= rext;
        RA_STAT: reg_rdata <= {status, {(REG_W-ST_W){1'b0}}};
        default: reg_rdata <= '0;
      endcase
    end
  end

  mbx_i2c_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(eng_active), .div(clk_div), .tick(tick)
  );

  mbx_i2c_engine #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .go_addr(c_addr),
    .go_rnw(c_rnw), .go_nbytes(c_nb), .go_hold(c_hold), .go_tx(wext),
    .sda_in(sda_s), .active(eng_active), .done(eng_done), .err(eng_err),
    .rx(eng_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  AST_BAD_MODE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !busy && !mode_ok) |=> (!busy && status[0])); // R11
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_hit) |=> ($stable(c_addr) && $stable(c_rnw) && $stable(c_nb))); // R10
  AST_BUSY_FALL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (status != '0)); // R5
  AST_ONE_FLAG_PER_DONE: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> $countones(status & ~$past(status)) <= 1); // R5
endmodule

// File: tb/mbx_i2c_master_bench.sv
`timescale 1ns/1ps
module mbx_i2c_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] clk_div = 16'd3;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        busy, scl_oe, sda_oe;
  logic        s_drive = 1'b0;
  wire         scl_w = ~scl_oe;
  wire         sda_w = ~(sda_oe | s_drive);

  always #2 clk = ~clk;

  mbx_i2c_master u_mbx_i2c_master (
    .clk(clk), .rst(rst), .clk_div(clk_div), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
  );

  int total = 0, bad = 0;
  bit fin = 1'b0;
  localparam logic [6:0] TGT = 7'h50;

  // target model and bus monitor
  logic [15:0] rd_pair = 16'h0;
  logic [7:0]  wr_log [2];
  logic [1:0]  mack;
  logic [7:0]  shift, addr_seen, tmp;
  int wr_cnt, starts, stops, nack_at = 0, bitn, bidx;
  int cyc = 0, last_rise = -1, gmin = 1 << 30, gmax = 0;
  bit act = 0, fresh = 0, rw = 0, mlast = 0, p_scl = 1, p_sda = 1;

  function automatic logic [7:0] rbyte(input int k);
    return (k == 1) ? rd_pair[7:0] : rd_pair[15:8];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (scl_w && p_scl && p_sda && !sda_w) begin
        starts++; act = 1; fresh = 1; bitn = 0; bidx = 0; s_drive = 0;
      end
      if (scl_w && p_scl && !p_sda && sda_w) begin
        stops++; act = 0; s_drive = 0;
      end
      if (scl_w && !p_scl) begin
        if (last_rise >= 0) begin
          if (cyc - last_rise < gmin) gmin = cyc - last_rise;
          if (cyc - last_rise > gmax) gmax = cyc - last_rise;
        end
        last_rise = cyc;
        if (act) begin
          if (bitn < 8 && (bidx == 0 || !rw)) shift = {shift[6:0], sda_w};
          if (bitn == 8 && rw && bidx > 0) begin mack[bidx-1] = sda_w; mlast = sda_w; end
        end
      end
      if (!scl_w && p_scl && act) begin
        if (fresh) fresh = 0;
        else if (bitn == 7) begin
          bitn = 8;
          if (bidx == 0) begin
            addr_seen = shift; rw = shift[0];
            if (shift[7:1] == TGT) s_drive = 1; else begin act = 0; s_drive = 0; end
          end else if (!rw) begin
            if (wr_cnt < 2) wr_log[wr_cnt] = shift;
            wr_cnt++;
            s_drive = (nack_at != bidx);
          end else s_drive = 0;
        end else if (bitn == 8) begin
          bitn = 0; bidx++;
          if (rw && (bidx == 1 || mlast == 0)) begin tmp = rbyte(bidx); s_drive = ~tmp[7]; end
          else s_drive = 0;
        end else begin
          bitn++;
          if (rw && bidx > 0) begin tmp = rbyte(bidx); s_drive = ~tmp[7-bitn]; end
        end
      end
      p_scl = scl_w; p_sda = sda_w;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  function automatic logic [15:0] mk(input logic [6:0] a, input bit wr, input int len, input bit hold);
    return {2'b10, hold, (len == 0), (len == 2), wr, 3'b000, a};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic run(input logic [15:0] cmd, input logic [15:0] wext, input bit clr);
    if (clr) wr_reg(2'd3, 16'hE000);
    wr_cnt = 0; starts = 0; stops = 0; gmin = 1 << 30; gmax = 0; last_rise = -1;
    mack = 2'b00;
    wr_reg(2'd1, wext);
    wr_reg(2'd0, cmd);
    wait_idle();
  endtask

  logic [15:0] v, prev;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines", {scl_oe, sda_oe}, 0);
    rd_reg(2'd3, v); chk(v == 0, "R1 status", v, 0);
    rd_reg(2'd2, v); chk(v == 0, "R1 rdmbx", v, 0);

    // sweep: direction x length
    for (int wr = 0; wr < 2; wr++) begin
      for (int len = 0; len < 3; len++) begin
        logic [15:0] wx, expr;
        wx = 16'h96E1 + 16'h0F0F * len[15:0];
        rd_pair = 16'h5AC3 ^ (16'h1248 * len[15:0]);
        rd_reg(2'd2, prev);
        run(mk(TGT, wr[0], len, 0), wx, 1);
        rd_reg(2'd3, v);
        chk(v == (wr ? 16'h4000 : 16'h8000), "R5 done flag", v, wr ? 16'h4000 : 16'h8000);
        chk(addr_seen == {TGT, ~wr[0]}, "R2 address byte", addr_seen, {TGT, ~wr[0]});
        chk(starts == 1 && stops == 1, "R13 start/stop count", {starts[15:0], stops[15:0]}, 32'h00010001);
        chk(gmin == 16 && gmax == 16, "R12 scl period", {gmin[15:0], gmax[15:0]}, 32'h00100010);
        if (wr) begin
          chk(wr_cnt == len, "R3 byte count", wr_cnt, len);
          if (len >= 1) chk(wr_log[0] == wx[7:0], "R3 first byte", wr_log[0], wx[7:0]);
          if (len == 2) chk(wr_log[1] == wx[15:8], "R3 second byte", wr_log[1], wx[15:8]);
        end else begin
          rd_reg(2'd2, v);
          expr = (len == 0) ? prev : (len == 1) ? {8'h00, rd_pair[7:0]} : rd_pair;
          chk(v == expr, (len == 0) ? "R7 probe keeps rdmbx" : "R4 read data", v, expr);
          if (len == 1) chk(mack[0] == 1, "R4 nack last", mack, 2'b01);
          if (len == 2) chk(mack == 2'b10, "R4 ack then nack", mack, 2'b10);
        end
        if (len == 0) chk(wr_cnt == 0, "R7 address only", wr_cnt, 0);
      end
    end

    // R12 other divider values
    for (int d = 4; d < 8; d += 2) begin
      clk_div = d[15:0];
      run(mk(TGT, 1, 2, 0), 16'h1234, 1);
      chk(gmin == 4 * (d + 1) && gmax == 4 * (d + 1), "R12 scl period div", gmax, 4 * (d + 1));
    end
    clk_div = 16'd3;

    // R6 address NACK
    run(mk(7'h23, 1, 2, 0), 16'hBEEF, 1);
    rd_reg(2'd3, v); chk(v == 16'h2000, "R6 addr nack status", v, 16'h2000);
    chk(wr_cnt == 0 && stops == 1, "R6 addr nack stop", {wr_cnt[15:0], stops[15:0]}, 32'h00000001);
    // R6 data NACK on first and second byte
    for (int k = 1; k < 3; k++) begin
      nack_at = k;
      run(mk(TGT, 1, 2, 0), 16'hC0DE, 1);
      rd_reg(2'd3, v); chk(v == 16'h2000, "R6 data nack status", v, 16'h2000);
      chk(wr_cnt == k, "R6 data phase cut", wr_cnt, k);
      chk(stops == 1, "R6 stop after nack", stops, 1);
    end
    nack_at = 0;
    // R7 probe to absent target
    rd_reg(2'd2, prev);
    run(mk(7'h11, 0, 0, 0), 16'h0, 1);
    rd_reg(2'd3, v); chk(v == 16'h2000, "R7 probe nack", v, 16'h2000);
    rd_reg(2'd2, v); chk(v == prev, "R7 rdmbx unchanged", v, prev);

    // R8 hold then chained read
    run(mk(TGT, 1, 1, 1), 16'h0007, 1);
    rd_reg(2'd3, v); chk(v == 16'h4000, "R8 held write done", v, 16'h4000);
    chk(stops == 0 && starts == 1, "R8 no stop", {starts[15:0], stops[15:0]}, 32'h00010000);
    chk(scl_oe == 1 && sda_oe == 0, "R8 scl held low", {scl_oe, sda_oe}, 2'b10);
    rd_pair = 16'hE17B;
    run(mk(TGT, 0, 2, 0), 16'h0, 1);
    chk(starts == 1 && stops == 1, "R8 repeated start", {starts[15:0], stops[15:0]}, 32'h00010001);
    rd_reg(2'd2, v); chk(v == 16'hE17B, "R8 chained read data", v, 16'hE17B);

    // R9 write-one-to-clear
    run(mk(TGT, 1, 1, 0), 16'h00AA, 1);
    run(mk(TGT, 0, 1, 0), 16'h0, 0);
    rd_reg(2'd3, v); chk(v == 16'hC000, "R9 sticky", v, 16'hC000);
    wr_reg(2'd3, 16'h4000);
    rd_reg(2'd3, v); chk(v == 16'h8000, "R9 clear one", v, 16'h8000);
    wr_reg(2'd3, 16'h0000);
    rd_reg(2'd3, v); chk(v == 16'h8000, "R9 zero keeps", v, 16'h8000);
    wr_reg(2'd3, 16'hE000);
    rd_reg(2'd3, v); chk(v == 16'h0000, "R9 clear all", v, 0);

    // R10 command while busy
    wr_cnt = 0; starts = 0; stops = 0;
    wr_reg(2'd1, 16'h3355);
    wr_reg(2'd0, mk(TGT, 1, 2, 0));
    wr_reg(2'd0, mk(7'h51, 0, 1, 0));
    wait_idle();
    chk(addr_seen == {TGT, 1'b0} && starts == 1, "R10 second cmd ignored", addr_seen, {TGT, 1'b0});
    rd_reg(2'd3, v); chk(v == 16'h4000, "R10 status", v, 16'h4000);
    chk(wr_cnt == 2 && wr_log[1] == 8'h33, "R10 data intact", wr_log[1], 8'h33);

    // R11 bad mode
    wr_reg(2'd3, 16'hE000);
    starts = 0;
    wr_reg(2'd0, {2'b00, 14'h0050});
    chk(busy == 0, "R11 busy low", busy, 0);
    repeat (50) @(negedge clk);
    rd_reg(2'd3, v); chk(v == 16'h2000, "R11 error flag", v, 16'h2000);
    chk(starts == 0 && scl_oe == 0, "R11 bus quiet", starts, 0);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule